// File: doc/BRIEF.md
# Processor-Hot Throttle Monitor and Override

This block watches two active-low processor-hot request lines and measures, over a programmable window, what fraction of the time each line is asserted. At the end of every window it publishes an 8-bit duty value per line, folds that value into a running two-period average, and raises a sticky alarm when the value is above a programmable limit. Software clears the alarm with a one-cycle acknowledge strobe. Both request lines pass through a two-flop synchroniser before they are counted. The time base is an externally supplied tick pulse, nominally 22.5 kHz.

The block also drives the two lines through open-drain pull-down outputs. In cross-couple mode, a request seen on either input causes the block to pull the opposite line low. In override mode, each line with its own enable bit set is pulled low by a shared PWM pattern. The pattern has a fixed 80-tick period, and a 4-bit code selects one of sixteen pulse widths. The `hot_n_i` inputs carry the level requested by the external parties. This sense path is kept apart from the block's own pull-downs, so cross-coupling cannot latch itself on.

Each channel is run by a meter state machine. Reset puts it in IDLE, and it moves IDLE->COUNT on the next cycle. It moves COUNT->PUBLISH on the last tick of a window and PUBLISH->COUNT one cycle later. The override generator is a second state machine. It leaves OFF for ON when any enable is set, and any state returns to OFF when no enable is set. It moves ON->REST when the pulse width is reached and REST->ON at the period wrap. At a wrap with the full-width code it stays ON->ON.

Top module: `phot_throttle_mon`

## Requirements
- R1: At the end of a window the current value becomes min(255, asserted_ticks * 256 / window_ticks), where asserted_ticks counts the ticks on which the synchronised input was low. 0 means never asserted, and 255 covers the fully asserted case.
- R2: The current value is 0 after reset. It changes only in the cycle after a window completes and otherwise holds the result of the last complete window.
- R3: Window select code k (0..9) gives a window of 2^(BASE_LOG2+k) ticks, and codes 10..15 behave as 9. The code is captured when a window starts.
- R4: The average is 0 after reset. At each window end it becomes floor((old average + new current value) / 2).
- R5: With cross-coupling enabled, a low level on either input makes the block pull the other line low. The pull-down appears two clock cycles after the input change (synchroniser latency).
- R6: An alarm bit sets at a window end when the new current value is strictly greater than its limit. An equal value does not set it. The alarm clears on an acknowledge strobe, and a set in the same cycle wins over the clear.
- R7: The override pattern has a period of exactly 80 ticks.
- R8: With override code c (0..15), each period holds the line low for (c+1)*5 ticks, so code 15 holds it low continuously. The code is captured at the start of each period.
- R9: A line is pulled low only while its override enable is set or cross-coupling is active for it. With both off, both pull-down outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base pulse (nominal 22.5 kHz) |
| hot_n_i | input | 2 | External processor-hot request levels, active low |
| short_en_i | input | 1 | Cross-couple enable |
| ovr_en_i | input | 2 | Per-line override enable |
| ovr_code_i | input | CODE_W | Override pulse-width code |
| win_sel0_i | input | SEL_W | Window select, line 0 |
| win_sel1_i | input | SEL_W | Window select, line 1 |
| limit0_i | input | VAL_W | Alarm limit, line 0 |
| limit1_i | input | VAL_W | Alarm limit, line 1 |
| alarm_ack_i | input | 2 | Alarm clear strobes |
| cur0_o | output | VAL_W | Current duty value, line 0 |
| cur1_o | output | VAL_W | Current duty value, line 1 |
| avg0_o | output | VAL_W | Averaged duty value, line 0 |
| avg1_o | output | VAL_W | Averaged duty value, line 1 |
| alarm_o | output | 2 | Sticky over-limit alarms |
| pull_low_o | output | 2 | Open-drain pull-down enables, 1 pulls the line low |

## Verification
The embedded assertions check the following on every cycle:
- the asserted-tick count never exceeds the window tick count;
- the current value moves only after PUBLISH;
- each new average lies between the old average and the new value;
- the captured window code never exceeds 9;
- an alarm rises only after a publish with an over-limit value;
- the PWM phase stays below 80 and the pulse never outlives its captured width;
- cross-coupling and the idle no-drive rule hold.

Only the bench scenarios can show the exact duty values for chosen patterns, the doubling of the window length, the average sequence 127/191/223, the equal-limit case, the measured 80-tick period, and the pulse counts per code.

// File: rtl/phot_pkg.sv
package phot_pkg;
    localparam int SEL_MAX = 9;

    typedef enum logic [1:0] {
        MW_IDLE    = 2'd0,
        MW_COUNT   = 2'd1,
        MW_PUBLISH = 2'd2
    } meter_st_e;

    typedef enum logic [1:0] {
        PW_OFF  = 2'd0,
        PW_ON   = 2'd1,
        PW_REST = 2'd2
    } pwm_st_e;
endpackage

// File: rtl/phot_sync.sv
module phot_sync #(
    parameter int W       = 2,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= {W{RST_VAL}};
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/phot_meter.sv
module phot_meter
    import phot_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int SEL_W     = 4,
    parameter int VAL_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hot_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [VAL_W-1:0] limit_i,
    input  logic             ack_i,
    output logic [VAL_W-1:0] cur_o,
    output logic [VAL_W-1:0] avg_o,
    output logic             alarm_o
);
    localparam int CW   = BASE_LOG2 + SEL_MAX + 1;
    localparam int SH_W = $clog2(CW + 1);
    localparam int MAXV = (1 << VAL_W) - 1;

    meter_st_e        st, st_nx;
    logic [SEL_W-1:0] sel_q, sel_clamped;
    logic [CW-1:0]    tick_cnt, hi_cnt, hi_total, hi_add, win_last, scaled;
    logic [SH_W-1:0]  win_log;
    logic [VAL_W-1:0] new_val, avg_nx;
    logic [VAL_W:0]   avg_sum;
    logic             last_tick;

    // Window code capture with clamping of out-of-range codes
    assign sel_clamped = (sel_i > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel_i;
    assign win_log     = SH_W'(BASE_LOG2) + SH_W'(sel_q);
    assign win_last    = (CW'(1) << win_log) - CW'(1);
    assign last_tick   = tick_i && (st == MW_COUNT) && (tick_cnt == win_last);
    assign hi_add      = hi_cnt + CW'(hot_i);

    // Scale asserted count to the 8-bit fraction of the window
    assign scaled  = hi_total >> (win_log - SH_W'(VAL_W));
    assign new_val = (scaled > CW'(MAXV)) ? VAL_W'(MAXV) : scaled[VAL_W-1:0];
    assign avg_sum = {1'b0, avg_o} + {1'b0, new_val};
    assign avg_nx  = avg_sum[VAL_W:1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= MW_IDLE;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            MW_IDLE:    st_nx = MW_COUNT;
            MW_COUNT:   if (last_tick) st_nx = MW_PUBLISH;
            MW_PUBLISH: st_nx = MW_COUNT;
            default:    st_nx = MW_IDLE;
        endcase
    end

    // Counters and published outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            tick_cnt <= '0;
            hi_cnt   <= '0;
            hi_total <= '0;
            cur_o    <= '0;
            avg_o    <= '0;
            alarm_o  <= 1'b0;
        end else begin
            if (st == MW_IDLE) begin
                sel_q    <= sel_clamped;
                tick_cnt <= '0;
                hi_cnt   <= '0;
            end else if (tick_i) begin
                if (last_tick) begin
                    hi_total <= hi_add;
                    tick_cnt <= '0;
                    hi_cnt   <= '0;
                end else begin
                    tick_cnt <= tick_cnt + CW'(1);
                    hi_cnt   <= hi_add;
                end
            end

            if (st == MW_PUBLISH) begin
                cur_o <= new_val;
                avg_o <= avg_nx;
                sel_q <= sel_clamped;
            end

            if ((st == MW_PUBLISH) && (new_val > limit_i)) alarm_o <= 1'b1;
            else if (ack_i)                                alarm_o <= 1'b0;
        end
    end

    AST_HI_WITHIN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= tick_cnt); // R1
    AST_CUR_ONLY_AFTER_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_o) |-> ($past(st) == MW_PUBLISH)); // R2
    AST_SEL_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q <= SEL_W'(SEL_MAX)); // R3
    AST_AVG_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MW_PUBLISH) |=> (((avg_o >= $past(avg_o)) || (avg_o >= cur_o)) &&
                                ((avg_o <= $past(avg_o)) || (avg_o <= cur_o)))); // R4
    AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> (($past(st) == MW_PUBLISH) && (cur_o > $past(limit_i)))); // R6
endmodule

// File: rtl/phot_ovr_pwm.sv
module phot_ovr_pwm
    import phot_pkg::*;
#(
    parameter int PERIOD = 80,
    parameter int STEP   = 5,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              pulse_o
);
    localparam int PH_W = $clog2(PERIOD + 1);

    pwm_st_e         st, st_nx;
    logic [PH_W-1:0] phase, width_q, width_new;
    logic            wrap;

    assign width_new = PH_W'((int'(code_i) + 1) * STEP);
    assign wrap      = tick_i && (phase == PH_W'(PERIOD - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PW_OFF;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            PW_OFF: if (run_i) st_nx = PW_ON;
            PW_ON: begin
                if (!run_i)                                  st_nx = PW_OFF;
                else if (wrap)                               st_nx = PW_ON;
                else if (tick_i && (phase + 1'b1 == width_q)) st_nx = PW_REST;
            end
            PW_REST: begin
                if (!run_i)    st_nx = PW_OFF;
                else if (wrap) st_nx = PW_ON;
            end
            default: st_nx = PW_OFF;
        endcase
    end

    // Phase counter and per-period width capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= '0;
            width_q <= PH_W'(STEP);
        end else if (st == PW_OFF) begin
            phase   <= '0;
            width_q <= width_new;
        end else if (tick_i) begin
            if (wrap) begin
                phase   <= '0;
                width_q <= width_new;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    always_comb pulse_o = (st == PW_ON);

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PH_W'(PERIOD)); // R7
    AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && run_i && (st != PW_OFF)) |=> (st == PW_ON) && (phase == '0)); // R7
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PW_ON) |-> (phase < width_q)); // R8
endmodule

// File: rtl/phot_throttle_mon.sv
module phot_throttle_mon #(
    parameter int BASE_LOG2  = 14,
    parameter int SEL_W      = 4,
    parameter int VAL_W      = 8,
    parameter int CODE_W     = 4,
    parameter int PWM_PERIOD = 80,
    parameter int PWM_STEP   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [1:0]        hot_n_i,
    input  logic              short_en_i,
    input  logic [1:0]        ovr_en_i,
    input  logic [CODE_W-1:0] ovr_code_i,
    input  logic [SEL_W-1:0]  win_sel0_i,
    input  logic [SEL_W-1:0]  win_sel1_i,
    input  logic [VAL_W-1:0]  limit0_i,
    input  logic [VAL_W-1:0]  limit1_i,
    input  logic [1:0]        alarm_ack_i,
    output logic [VAL_W-1:0]  cur0_o,
    output logic [VAL_W-1:0]  cur1_o,
    output logic [VAL_W-1:0]  avg0_o,
    output logic [VAL_W-1:0]  avg1_o,
    output logic [1:0]        alarm_o,
    output logic [1:0]        pull_low_o
);
    localparam int NCH = 2;

    logic [NCH-1:0]   hot_sync_n, hot_act;
    logic [SEL_W-1:0] sel_a   [NCH];
    logic [VAL_W-1:0] lim_a   [NCH];
    logic [VAL_W-1:0] cur_a   [NCH];
    logic [VAL_W-1:0] avg_a   [NCH];
    logic             pwm_pulse;

    assign sel_a[0] = win_sel0_i;
    assign sel_a[1] = win_sel1_i;
    assign lim_a[0] = limit0_i;
    assign lim_a[1] = limit1_i;
    assign cur0_o   = cur_a[0];
    assign cur1_o   = cur_a[1];
    assign avg0_o   = avg_a[0];
    assign avg1_o   = avg_a[1];

    phot_sync #(.W(NCH), .STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (hot_n_i),
        .q_o   (hot_sync_n)
    );

    assign hot_act = ~hot_sync_n;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_meter
        phot_meter #(
            .BASE_LOG2 (BASE_LOG2),
            .SEL_W     (SEL_W),
            .VAL_W     (VAL_W)
        ) u_meter (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .hot_i   (hot_act[ch]),
            .sel_i   (sel_a[ch]),
            .limit_i (lim_a[ch]),
            .ack_i   (alarm_ack_i[ch]),
            .cur_o   (cur_a[ch]),
            .avg_o   (avg_a[ch]),
            .alarm_o (alarm_o[ch])
        );
    end

    phot_ovr_pwm #(
        .PERIOD (PWM_PERIOD),
        .STEP   (PWM_STEP),
        .CODE_W (CODE_W)
    ) u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .run_i   (|ovr_en_i),
        .code_i  (ovr_code_i),
        .pulse_o (pwm_pulse)
    );

    // Pull-down drive: override pattern or cross-coupled request of the other line
    always_comb begin
        for (int ch = 0; ch < NCH; ch++) begin
            pull_low_o[ch] = (ovr_en_i[ch] && pwm_pulse) ||
                             (short_en_i && hot_act[NCH-1-ch]);
        end
    end

    AST_SHORT_0_TO_1: assert property (@(posedge clk) disable iff (!rst_n)
        (short_en_i && !$past(hot_n_i[0], 2)) |-> pull_low_o[1]); // R5
    AST_SHORT_1_TO_0: assert property (@(posedge clk) disable iff (!rst_n)
        (short_en_i && !$past(hot_n_i[1], 2)) |-> pull_low_o[0]); // R5
    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!short_en_i && (ovr_en_i == 2'b00)) |-> (pull_low_o == 2'b00)); // R9
endmodule

// File: tb/phot_throttle_mon_test.sv
module phot_throttle_mon_test;
    localparam int BASE = 8;
    localparam int WIN0 = 1 << BASE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] hot_n = 2'b11;
    logic       short_en = 1'b0;
    logic [1:0] ovr_en = 2'b00;
    logic [3:0] ovr_code = 4'd0;
    logic [3:0] sel0 = 4'd0, sel1 = 4'd1;
    logic [7:0] lim0 = 8'd254, lim1 = 8'd255;
    logic [1:0] ack = 2'b00;
    logic [7:0] cur0, cur1, avg0, avg1;
    logic [1:0] alarm, pull;

    int n_chk = 0, n_fail = 0;
    int a0 = 16, a1 = 16;

    phot_throttle_mon #(.BASE_LOG2(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .hot_n_i(hot_n),
        .short_en_i(short_en), .ovr_en_i(ovr_en), .ovr_code_i(ovr_code),
        .win_sel0_i(sel0), .win_sel1_i(sel1), .limit0_i(lim0), .limit1_i(lim1),
        .alarm_ack_i(ack), .cur0_o(cur0), .cur1_o(cur1), .avg0_o(avg0), .avg1_o(avg1),
        .alarm_o(alarm), .pull_low_o(pull)
    );

    always #5 clk = ~clk;

    // Tick every fourth cycle, driven at the falling edge
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc++;
            tick = (tc % 4 == 0);
        end
    end

    // Input pattern: low for a ticks out of every 16
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            if (tick) begin
                @(negedge clk);
                ph = (ph == 15) ? 0 : ph + 1;
                hot_n[0] = !(ph < a0);
                hot_n[1] = !(ph < a1);
            end
        end
    end

    function automatic int exp_cur(input int a);
        int v = a * 16;
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int win_len(input int s);
        return WIN0 << s;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!tick);
        end
        @(negedge clk);
    endtask

    task automatic count_low(input int idx, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            wait_ticks(1);
            if (pull[idx]) c++;
        end
    endtask

    initial begin
        int c, c1, t;
        bit prev;
        int ns0, ns1, os_max, ns_max, e0, e1;
        void'($urandom(32'd7321));

        // Inputs held asserted across reset
        hot_n = 2'b00;
        repeat (4) @(negedge clk);
        check_eq("R2 reset cur0", cur0, 0);
        check_eq("R4 reset avg0", avg0, 0);
        check_eq("R6 reset alarm", alarm, 0);
        check_eq("R9 reset pull", pull, 0);
        rst_n = 1'b1;

        wait_ticks(WIN0 / 2);
        check_eq("R2 cur0 before first window", cur0, 0);
        wait_ticks(WIN0);
        check_eq("R1 cur0 full assertion", cur0, 255);
        check_eq("R4 avg0 first window", avg0, 127);
        check_eq("R3 cur1 double window not done", cur1, 0);
        check_eq("R6 alarm0 above limit", alarm[0], 1);
        wait_ticks(WIN0);
        check_eq("R4 avg0 second window", avg0, 191);
        check_eq("R3 cur1 after double window", cur1, 255);
        check_eq("R4 avg1 first window", avg1, 127);
        check_eq("R6 alarm1 equal to limit", alarm[1], 0);
        wait_ticks(WIN0);
        check_eq("R4 avg0 third window", avg0, 223);
        ack = 2'b01;
        @(negedge clk);
        ack = 2'b00;
        @(negedge clk);
        check_eq("R6 alarm0 cleared by ack", alarm[0], 0);

        // Random duty patterns, windows and limits
        for (int it = 0; it < 6; it++) begin
            os_max = (sel0 > sel1) ? win_len(sel0) : win_len(sel1);
            ns0 = $urandom % 3;
            ns1 = $urandom % 3;
            ns_max = (ns0 > ns1) ? win_len(ns0) : win_len(ns1);
            a0 = $urandom % 17;
            a1 = $urandom % 17;
            e0 = exp_cur(a0);
            e1 = exp_cur(a1);
            t = e0 - 1 + int'($urandom % 3);
            lim0 = (t < 0) ? 8'd0 : (t > 255) ? 8'd255 : 8'(t);
            lim1 = 8'($urandom % 256);
            sel0 = 4'(ns0);
            sel1 = 4'(ns1);
            wait_ticks(2 * os_max + ns_max + 16);
            check_eq("R1 random cur0", cur0, e0);
            check_eq("R1 random cur1", cur1, e1);
            ack = 2'b11;
            @(negedge clk);
            ack = 2'b00;
            wait_ticks(ns_max + 16);
            check_eq("R6 random alarm0", alarm[0], (e0 > lim0) ? 1 : 0);
            check_eq("R6 random alarm1", alarm[1], (e1 > lim1) ? 1 : 0);
        end

        // Cross-coupling
        short_en = 1'b1;
        a0 = 16; a1 = 0;
        wait_ticks(4);
        check_eq("R5 line0 request pulls line1", pull[1], 1);
        check_eq("R5 line0 itself not pulled", pull[0], 0);
        a0 = 0; a1 = 16;
        wait_ticks(4);
        check_eq("R5 line1 request pulls line0", pull[0], 1);
        check_eq("R5 line1 released", pull[1], 0);
        short_en = 1'b0;
        a0 = 16; a1 = 0;
        wait_ticks(4);
        check_eq("R9 no drive with modes off", pull, 0);

        // Override PWM
        ovr_en = 2'b01;
        ovr_code = 4'd0;
        wait_ticks(100);
        count_low(0, 80, c);
        check_eq("R8 code 0 pulse ticks", c, 5);
        ovr_code = 4'd15;
        wait_ticks(100);
        count_low(0, 80, c);
        check_eq("R8 code 15 pulse ticks", c, 80);
        ovr_code = 4'd7;
        wait_ticks(100);
        count_low(0, 80, c);
        count_low(1, 80, c1);
        check_eq("R8 code 7 pulse ticks", c, 40);
        check_eq("R9 disabled line not overridden", c1, 0);
        prev = pull[0];
        t = 0;
        while (!(pull[0] && !prev) && t < 200) begin
            prev = pull[0];
            wait_ticks(1);
            t++;
        end
        t = 0;
        prev = pull[0];
        do begin
            prev = pull[0];
            wait_ticks(1);
            t++;
        end while (!(pull[0] && !prev) && t < 200);
        check_eq("R7 override period ticks", t, 80);
        ovr_en = 2'b00;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule